// File: doc/BRIEF.md
# Parallel Port Host Register Interface

This block is the register file that a host CPU sees for a PC-style parallel port. A simple synchronous bus addresses a small offset space: a data register at offset 0, a read-only status view at offset 1 and a control register at offset 2. The data register drives the eight data pins directly, control bit 0 drives the active-low strobe pin, and five peripheral status lines are synchronized and presented on the status register.

A 3-bit mode input gives offset 0 its meaning. In the two plain port modes (000 and 001) an offset-0 write latches the byte onto the data pins. In the ECP mode (011) with the forward direction, an offset-0 write is pushed into a 16-entry transmit FIFO with a tag bit set to 1, marking the byte as an address/RLE byte for the downstream handshake engine, which drains the FIFO through a pop input. Read data is a combinational function of the bus address and is valid whenever the address is held.

Top module: `pport_host_regs`

## Requirements
- R1: After reset the data pins drive 0x00, the control register and ctrl_o are 0, strobe_no is 1, the FIFO is empty and not full, and the overflow flag is 0.
- R2: In mode 000 or 001, a write to offset 0 makes pd_o equal to the written byte (no inversion) from the next clock edge.
- R3: Reading offset 0 returns the current level of pd_i.
- R4: In mode 011 with dir_rev_i = 0, a write to offset 0 pushes the byte into the FIFO with tag bit 1 and leaves pd_o unchanged.
- R5: An offset-0 write in mode 011 with dir_rev_i = 1, or in any mode other than 000, 001 and 011, changes neither pd_o nor the FIFO.
- R6: The FIFO returns bytes in write order on fifo_data_o (show-ahead, the oldest entry shown while not empty), a pop with fifo_pop_i removes it, fifo_full_o is 1 with 16 entries held and fifo_empty_o is 1 with none.
- R7: A push attempt while the FIFO is full and no pop happens in the same cycle is dropped and sets fifo_ovf_o, which stays 1 until reset.
- R8: A push and a pop in the same cycle both take effect; a full FIFO then accepts the push and stays full, and an empty FIFO ignores the pop and accepts the push.
- R9: Reading offset 1 returns bits 2..0 as 0, bit 3 = fault_ni, bit 4 = select_i, bit 5 = perror_i, bit 6 = ack_ni and bit 7 = NOT busy_i, each taken through a two-flop synchronizer so that an input change shows after the second clock edge.
- R10: A write to offset 2 stores bits 5..0 into the control register, which appears on ctrl_o; reading offset 2 returns those bits with bits 7..6 as 0.
- R11: strobe_no is the complement of control bit 0.
- R12: Reads of offsets 3 to 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 3 | Register offset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed offset |
| mode_i | input | 3 | Port mode field |
| dir_rev_i | input | 1 | Direction, 1 = reverse |
| pd_o | output | 8 | Data pins, driven value |
| pd_i | input | 8 | Data pins, sensed level |
| strobe_no | output | 1 | Strobe pin, active low |
| ctrl_o | output | 6 | Stored control bits 5..0 |
| fault_ni | input | 1 | Peripheral fault, active low |
| select_i | input | 1 | Peripheral selected |
| perror_i | input | 1 | Paper error |
| ack_ni | input | 1 | Acknowledge, active low |
| busy_i | input | 1 | Peripheral busy |
| fifo_pop_i | input | 1 | Pop request from the transmit engine |
| fifo_data_o | output | 8 | Oldest FIFO byte |
| fifo_tag_o | output | 1 | Tag of the oldest entry, 1 = address/RLE |
| fifo_full_o | output | 1 | FIFO holds 16 entries |
| fifo_empty_o | output | 1 | FIFO holds no entry |
| fifo_ovf_o | output | 1 | Sticky dropped-push flag |

## Verification
A host push from an offset-0 write and a pop from the transmit engine can land on the same edge. The bench provokes this with the FIFO full, where the push must be accepted and the FIFO must stay full with no overflow, and with the FIFO empty, where the pop must be ignored and the pushed byte must appear. A scoreboard queue holds every byte the bench expects to be accepted, and a monitor compares each popped byte and tag against it, so a lost, duplicated or reordered entry shows as a mismatch.

// File: rtl/pport_pkg.sv
package pport_pkg;
  typedef enum logic [2:0] {
    MODE_SPP   = 3'b000,
    MODE_BIDIR = 3'b001,
    MODE_DFIFO = 3'b010,
    MODE_ECP   = 3'b011,
    MODE_EPP   = 3'b100,
    MODE_RSVD  = 3'b101,
    MODE_TEST  = 3'b110,
    MODE_CFG   = 3'b111
  } pport_mode_e;

  localparam int unsigned OFF_DATA = 0;
  localparam int unsigned OFF_STAT = 1;
  localparam int unsigned OFF_CTRL = 2;

  localparam int unsigned CTRL_W = 6;
  localparam logic TAG_ADDR_RLE = 1'b1;

  typedef struct packed {
    logic       tag;
    logic [7:0] data;
  } fifo_ent_t;
endpackage

// File: rtl/pport_status_sync.sv
module pport_status_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pport_tx_fifo.sv
module pport_tx_fifo #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             ovf_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             do_pop, do_push;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_FULL);
  assign do_pop  = pop_i && !empty_o;
  // a pop in the same cycle frees the slot the push needs
  assign do_push = push_i && (!full_o || do_pop);

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      if (push_i && !do_push) ovf_q <= 1'b1;
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/pport_rd_mux.sv
module pport_rd_mux
  import pport_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        pins_i,
  input  logic [4:0]        stat_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [7:0]        rdata_o
);
  // stat_i = {busy, ack_n, perror, select, fault_n}
  always_comb begin
    rdata_o = 8'h00;
    unique case (addr_i)
      ADDR_W'(OFF_DATA): rdata_o = pins_i;
      ADDR_W'(OFF_STAT): rdata_o = {~stat_i[4], stat_i[3:0], 3'b000};
      ADDR_W'(OFF_CTRL): rdata_o = {{(8 - CTRL_W){1'b0}}, ctrl_i};
      default:           rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/pport_host_regs.sv
module pport_host_regs
  import pport_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned FIFO_DEPTH  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic [2:0]        mode_i,
  input  logic              dir_rev_i,
  output logic [7:0]        pd_o,
  input  logic [7:0]        pd_i,
  output logic              strobe_no,
  output logic [5:0]        ctrl_o,
  input  logic              fault_ni,
  input  logic              select_i,
  input  logic              perror_i,
  input  logic              ack_ni,
  input  logic              busy_i,
  input  logic              fifo_pop_i,
  output logic [7:0]        fifo_data_o,
  output logic              fifo_tag_o,
  output logic              fifo_full_o,
  output logic              fifo_empty_o,
  output logic              fifo_ovf_o
);
  localparam int unsigned STAT_W = 5;
  localparam int unsigned ENT_W  = $bits(fifo_ent_t);

  pport_mode_e       mode;
  logic              wr_data, wr_ctrl;
  logic              data_port_mode, ecp_fwd;
  logic [7:0]        data_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [STAT_W-1:0] stat_raw, stat_sync;
  fifo_ent_t         push_ent, head_ent;

  assign mode    = pport_mode_e'(mode_i);
  assign wr_data = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_DATA));
  assign wr_ctrl = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_CTRL));

  assign data_port_mode = (mode == MODE_SPP) || (mode == MODE_BIDIR);
  assign ecp_fwd        = (mode == MODE_ECP) && !dir_rev_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= 8'h00;
      ctrl_q <= '0;
    end else begin
      if (wr_data && data_port_mode) data_q <= bus_wdata_i;
      if (wr_ctrl) ctrl_q <= bus_wdata_i[CTRL_W-1:0];
    end
  end

  assign pd_o      = data_q;
  assign ctrl_o    = ctrl_q;
  assign strobe_no = ~ctrl_q[0];

  assign stat_raw = {busy_i, ack_ni, perror_i, select_i, fault_ni};

  pport_status_sync #(
    .WIDTH (STAT_W),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(stat_raw),
    .sync_o (stat_sync)
  );

  assign push_ent.tag  = TAG_ADDR_RLE;
  assign push_ent.data = bus_wdata_i;

  pport_tx_fifo #(
    .WIDTH(ENT_W),
    .DEPTH(FIFO_DEPTH)
  ) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (wr_data && ecp_fwd),
    .wdata_i(push_ent),
    .pop_i  (fifo_pop_i),
    .rdata_o(head_ent),
    .full_o (fifo_full_o),
    .empty_o(fifo_empty_o),
    .ovf_o  (fifo_ovf_o)
  );

  assign fifo_data_o = head_ent.data;
  assign fifo_tag_o  = head_ent.tag;

  pport_rd_mux #(
    .ADDR_W(ADDR_W)
  ) u_rd_mux (
    .addr_i (bus_addr_i),
    .pins_i (pd_i),
    .stat_i (stat_sync),
    .ctrl_i (ctrl_q),
    .rdata_o(bus_rdata_o)
  );
endmodule

// File: rtl/pport_host_regs_chk.sv
module pport_host_regs_chk #(
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic [7:0]        bus_wdata_i,
  input logic [7:0]        bus_rdata_o,
  input logic [2:0]        mode_i,
  input logic              dir_rev_i,
  input logic [7:0]        pd_o,
  input logic              strobe_no,
  input logic              fault_ni,
  input logic              select_i,
  input logic              perror_i,
  input logic              ack_ni,
  input logic              busy_i,
  input logic              fifo_pop_i,
  input logic              fifo_full_o,
  input logic              fifo_empty_o,
  input logic              fifo_ovf_o
);
  logic [1:0] run_cnt_q;
  logic       wr0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_cnt_q <= '0;
    else if (run_cnt_q != 2'd3) run_cnt_q <= run_cnt_q + 1'b1;
  end

  assign wr0 = bus_wr_i && (bus_addr_i == '0);

  AST_DATA_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr0 && (mode_i == 3'b000 || mode_i == 3'b001) |=> pd_o == $past(bus_wdata_i)); // R2
  AST_ECP_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr0 && mode_i == 3'b011 && !dir_rev_i && fifo_empty_o |=> !fifo_empty_o); // R4
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr0 && mode_i != 3'b000 && mode_i != 3'b001 |=> $stable(pd_o)); // R5
  AST_REV_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr0 && mode_i == 3'b011 && dir_rev_i && fifo_empty_o |=> fifo_empty_o); // R5
  AST_FULL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_full_o && fifo_empty_o)); // R6
  AST_NO_OVF_ON_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_ovf_o && fifo_pop_i && fifo_full_o |=> !fifo_ovf_o); // R8
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_ovf_o |=> fifo_ovf_o); // R7
  AST_STAT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_i == ADDR_W'(1) |-> bus_rdata_o[2:0] == 3'b000); // R9
  AST_STAT_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt_q >= 2'd2 && bus_addr_i == ADDR_W'(1) |->
      bus_rdata_o[7:3] == {~$past(busy_i, 2), $past(ack_ni, 2), $past(perror_i, 2),
                           $past(select_i, 2), $past(fault_ni, 2)}); // R9
  AST_CTRL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_i == ADDR_W'(2) |-> bus_rdata_o[7:6] == 2'b00); // R10
  AST_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_i && bus_addr_i == ADDR_W'(2) |=> strobe_no == !$past(bus_wdata_i[0])); // R11
  AST_UNMAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_i >= ADDR_W'(3) |-> bus_rdata_o == 8'h00); // R12
endmodule

bind pport_host_regs pport_host_regs_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_pport_host_regs.sv
module sim_pport_host_regs;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] mode = 3'b000;
  logic       dir_rev = 1'b0;
  logic [7:0] pd_out;
  logic [7:0] pd_in = 8'h00;
  logic       strobe_n;
  logic [5:0] ctrl;
  logic       fault_n = 1'b1, sel = 1'b0, perr = 1'b0, ack_n = 1'b1, busy = 1'b0;
  logic       pop = 1'b0;
  logic [7:0] f_data;
  logic       f_tag, f_full, f_empty, f_ovf;

  int checks = 0;
  int failures = 0;
  int model_cnt = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  pport_host_regs u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .mode_i(mode), .dir_rev_i(dir_rev),
    .pd_o(pd_out), .pd_i(pd_in), .strobe_no(strobe_n), .ctrl_o(ctrl),
    .fault_ni(fault_n), .select_i(sel), .perror_i(perr), .ack_ni(ack_n), .busy_i(busy),
    .fifo_pop_i(pop), .fifo_data_o(f_data), .fifo_tag_o(f_tag),
    .fifo_full_o(f_full), .fifo_empty_o(f_empty), .fifo_ovf_o(f_ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one bus/pop cycle; scoreboard gets every byte the FIFO must accept
  task automatic step(input logic w, input logic [2:0] a, input logic [7:0] d, input logic p);
    bit push_try, pop_ok, acc;
    wr = w; addr = a; wdata = d; pop = p;
    push_try = w && a == 3'd0 && mode == 3'b011 && !dir_rev;
    pop_ok = p && model_cnt > 0;
    acc = push_try && (model_cnt < DEPTH || pop_ok);
    if (acc) exp_q.push_back(d);
    model_cnt += int'(acc) - int'(pop_ok);
    @(posedge clk); #1;
    wr = 1'b0; pop = 1'b0;
  endtask

  // monitor: compare each popped head entry with the scoreboard
  always @(negedge clk) begin
    if (rst_n && pop && !f_empty) begin
      if (exp_q.size() == 0) chk("R6 pop with empty scoreboard", 32'(f_data), 32'hx);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk("R6 fifo order", 32'(f_data), 32'(e));
        chk("R4 fifo tag", 32'(f_tag), 32'd1);
      end
    end
  end

  task automatic drain();
    while (model_cnt > 0) step(1'b0, 3'd0, 8'h00, 1'b1);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk("R1 pd_o", 32'(pd_out), 32'h00);
    chk("R1 ctrl_o", 32'(ctrl), 32'h00);
    chk("R1 strobe_no", 32'(strobe_n), 32'd1);
    chk("R1 empty/full/ovf", {f_empty, f_full, f_ovf}, 3'b100);

    // R2 data port modes
    mode = 3'b000; step(1'b1, 3'd0, 8'hA5, 1'b0);
    chk("R2 mode000 latch", 32'(pd_out), 32'hA5);
    mode = 3'b001; step(1'b1, 3'd0, 8'h3C, 1'b0);
    chk("R2 mode001 latch", 32'(pd_out), 32'h3C);

    // R3 pin readback
    pd_in = 8'h5A; addr = 3'd0; #1;
    chk("R3 read pins", 32'(rdata), 32'h5A);
    pd_in = 8'hC3; #1;
    chk("R3 read pins", 32'(rdata), 32'hC3);

    // R5 ignored writes
    mode = 3'b010; step(1'b1, 3'd0, 8'hFF, 1'b0);
    mode = 3'b111; step(1'b1, 3'd0, 8'h11, 1'b0);
    mode = 3'b011; dir_rev = 1'b1; step(1'b1, 3'd0, 8'h22, 1'b0);
    chk("R5 pd_o unchanged", 32'(pd_out), 32'h3C);
    chk("R5 fifo still empty", 32'(f_empty), 32'd1);
    dir_rev = 1'b0;

    // R4 ECP pushes
    step(1'b1, 3'd0, 8'h81, 1'b0);
    step(1'b1, 3'd0, 8'h42, 1'b0);
    step(1'b1, 3'd0, 8'h07, 1'b0);
    chk("R4 pd_o unchanged", 32'(pd_out), 32'h3C);
    chk("R4 not empty", 32'(f_empty), 32'd0);
    chk("R4 head byte", 32'(f_data), 32'h81);
    drain();
    chk("R6 empty after drain", 32'(f_empty), 32'd1);

    // R6/R7 fill, overflow
    for (int i = 0; i < DEPTH; i++) step(1'b1, 3'd0, 8'(8'h10 + i), 1'b0);
    chk("R6 full at depth", 32'(f_full), 32'd1);
    chk("R7 no ovf yet", 32'(f_ovf), 32'd0);
    step(1'b1, 3'd0, 8'hEE, 1'b0);
    chk("R7 ovf set", 32'(f_ovf), 32'd1);
    chk("R7 still full", 32'(f_full), 32'd1);

    // R8 push+pop while full
    step(1'b1, 3'd0, 8'h99, 1'b1);
    chk("R8 full kept", 32'(f_full), 32'd1);
    drain();
    chk("R7 ovf sticky", 32'(f_ovf), 32'd1);
    chk("R6 empty", 32'(f_empty), 32'd1);

    // R8 push+pop while empty
    step(1'b1, 3'd0, 8'h5E, 1'b1);
    chk("R8 push kept when empty", 32'(f_empty), 32'd0);
    chk("R8 head", 32'(f_data), 32'h5E);
    drain();

    // R9 status through synchronizer
    addr = 3'd1;
    fault_n = 1'b0; sel = 1'b1; perr = 1'b0; ack_n = 1'b1; busy = 1'b1;
    @(posedge clk); #1;
    chk("R9 old after one edge", 32'(rdata), 32'hC8);
    @(posedge clk); #1;
    chk("R9 pattern A", 32'(rdata), 32'h50);
    fault_n = 1'b1; sel = 1'b0; perr = 1'b1; ack_n = 1'b0; busy = 1'b0;
    repeat (2) @(posedge clk); #1;
    chk("R9 pattern B", 32'(rdata), 32'hA8);

    // R10/R11 control
    step(1'b1, 3'd2, 8'hFF, 1'b0);
    addr = 3'd2; #1;
    chk("R10 ctrl read", 32'(rdata), 32'h3F);
    chk("R10 ctrl_o", 32'(ctrl), 32'h3F);
    chk("R11 strobe low", 32'(strobe_n), 32'd0);
    step(1'b1, 3'd2, 8'hC2, 1'b0);
    addr = 3'd2; #1;
    chk("R10 ctrl read", 32'(rdata), 32'h02);
    chk("R11 strobe high", 32'(strobe_n), 32'd1);

    // R12 unmapped
    for (int a = 3; a < 8; a++) begin
      addr = 3'(a); #1;
      chk("R12 unmapped read", 32'(rdata), 32'h00);
    end

    chk("R6 scoreboard drained", 32'(exp_q.size()), 32'd0);
    summary();
  end
endmodule